// File: doc/BRIEF.md
# Associative Page Frame Translator

This block translates a 21-bit virtual word address into a physical core address by holding one register per physical page frame. Each register records which virtual block currently sits in its frame, whether that record is valid, and a lock bit. On a lookup, every register compares its block number against the requested one at the same time. The matching frame number, joined with the word offset, forms the physical address.

A lookup on a locked frame is refused with a lock fault. A lock marks a frame that is still being filled, or one that the running program may not touch. A lookup that matches no register raises a miss fault, so that the fault logic outside can bring the block in. When the top address bit is set, the access goes to the read-only executive store. Such an access passes through untranslated and never faults.

Software outside the block fills frames through a load port. A separate control sets or clears a single frame's lock bit. Lookups arrive as a valid/ready stream. The response is produced combinationally in the same cycle, so the request is accepted exactly when the consumer is ready.

Top module: `pat_xlate`

## Requirements
- R1: After reset every frame register is empty, so every main-store lookup raises the miss fault.
- R2: The address fields are: bit 20 selects the executive store, bits 19..9 are the block number and bits 8..0 are the word offset.
- R3: A lookup with bit 20 set asserts rsp_exec and returns address bits 19..0 on rsp_eaddr. It raises no fault, no multi-hit flag, and rsp_paddr is zero, whatever the frame registers hold.
- R4: A lookup that matches an unlocked frame returns rsp_paddr = {frame number (5 bits), offset (9 bits)} in the same cycle, with no fault.
- R5: A main-store lookup that matches no valid register asserts rsp_fault_miss and returns rsp_paddr zero.
- R6: A lookup whose selected frame is locked asserts rsp_fault_lock (not rsp_fault_miss) and returns rsp_paddr zero.
- R7: A load (wr_en) writes block number and lock bit into wr_frame and marks it valid, taking effect from the next cycle. The block previously held in that frame no longer matches.
- R8: The lock control (lk_en) changes only the lock bit of lk_frame. The stored block stays, so a locked block then gives a lock fault and an unlocked one hits again.
- R9: When a load and a lock control target the same frame in the same cycle, the load's lock bit wins.
- R10: If several valid registers match, rsp_multi is asserted and the lowest-numbered matching frame supplies both the physical address and the lock decision.
- R11: rsp_valid follows req_valid and req_ready follows rsp_ready. While req_valid is low, every response data and flag output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load a frame register |
| wr_frame | input | 5 | Frame to load |
| wr_block | input | 11 | Block number to store |
| wr_lock | input | 1 | Lock bit to store |
| lk_en | input | 1 | Change one frame's lock bit only |
| lk_frame | input | 5 | Frame whose lock changes |
| lk_val | input | 1 | New lock value |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup accepted (equals rsp_ready) |
| req_addr | input | 21 | Virtual address |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer ready for response |
| rsp_paddr | output | 14 | Physical core address on a clean hit |
| rsp_eaddr | output | 20 | Executive store address on a bypass |
| rsp_exec | output | 1 | Access went to the executive store |
| rsp_fault_miss | output | 1 | Block not resident |
| rsp_fault_lock | output | 1 | Selected frame is locked |
| rsp_multi | output | 1 | More than one frame matched |

## Verification
The lookup is combinational on registered state, so a corrupted frame register shows on the very first lookup of the affected block after the bad write. It appears as a wrong frame in rsp_paddr, a miss where a hit is due, or a hit where a miss is due. A lost or stray lock bit turns a lock fault into a clean hit, or the reverse, in the cycle after the lock control. A valid bit that survives reset makes a lookup of block zero hit instead of miss. A priority error between matching frames shows as the wrong frame number or wrong lock decision whenever rsp_multi is raised.

// File: rtl/pat_pkg.sv
package pat_pkg;
  localparam int PAT_BLK_W  = 11;
  localparam int PAT_OFF_W  = 9;
  localparam int PAT_FRAMES = 32;

  typedef struct packed {
    logic multi;
    logic exec;
    logic flock;
    logic fmiss;
  } pat_flags_t;
endpackage

// File: rtl/pat_entry.sv
module pat_entry #(
  parameter int BLK_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [BLK_W-1:0] ld_block,
  input  logic             ld_lock,
  input  logic             lk,
  input  logic             lk_val,
  input  logic [BLK_W-1:0] cmp_block,
  output logic             match,
  output logic             locked
);
  logic             vld_q;
  logic             lock_q;
  logic [BLK_W-1:0] blk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      lock_q <= 1'b0;
      blk_q  <= '0;
    end else if (ld) begin
      vld_q  <= 1'b1;
      lock_q <= ld_lock;
      blk_q  <= ld_block;
    end else if (lk) begin
      lock_q <= lk_val;
    end
  end

  assign match  = vld_q && (blk_q == cmp_block);
  assign locked = lock_q;
endmodule

// File: rtl/pat_prio.sv
module pat_prio #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  hits,
  output logic [IW-1:0] idx,
  output logic          any,
  output logic          multi
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) idx = IW'(i);
    end
  end

  assign any   = |hits;
  assign multi = |(hits & (hits - N'(1)));
endmodule

// File: rtl/pat_xlate.sv
module pat_xlate
  import pat_pkg::*;
#(
  parameter int BLK_W  = PAT_BLK_W,
  parameter int OFF_W  = PAT_OFF_W,
  parameter int FRAMES = PAT_FRAMES,
  localparam int FRM_W = $clog2(FRAMES),
  localparam int VA_W  = BLK_W + OFF_W + 1,
  localparam int PA_W  = FRM_W + OFF_W,
  localparam int EA_W  = BLK_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [FRM_W-1:0] wr_frame,
  input  logic [BLK_W-1:0] wr_block,
  input  logic             wr_lock,
  input  logic             lk_en,
  input  logic [FRM_W-1:0] lk_frame,
  input  logic             lk_val,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_addr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [EA_W-1:0]  rsp_eaddr,
  output logic             rsp_exec,
  output logic             rsp_fault_miss,
  output logic             rsp_fault_lock,
  output logic             rsp_multi
);
  logic             exec_sel;
  logic [BLK_W-1:0] req_blk;
  logic [OFF_W-1:0] req_off;
  logic [FRAMES-1:0] hit_vec;
  logic [FRAMES-1:0] lock_vec;
  logic [FRM_W-1:0] win_idx;
  logic             any_hit;
  logic             many_hit;
  pat_flags_t       flags;

  assign exec_sel = req_addr[VA_W-1];
  assign req_blk  = req_addr[VA_W-2 -: BLK_W];
  assign req_off  = req_addr[OFF_W-1:0];

  for (genvar g = 0; g < FRAMES; g++) begin : g_frame
    pat_entry #(.BLK_W(BLK_W)) u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (wr_en && (wr_frame == FRM_W'(g))),
      .ld_block (wr_block),
      .ld_lock  (wr_lock),
      .lk       (lk_en && (lk_frame == FRM_W'(g))),
      .lk_val   (lk_val),
      .cmp_block(req_blk),
      .match    (hit_vec[g]),
      .locked   (lock_vec[g])
    );
  end

  pat_prio #(.N(FRAMES), .IW(FRM_W)) u_prio (
    .hits (hit_vec),
    .idx  (win_idx),
    .any  (any_hit),
    .multi(many_hit)
  );

  always_comb begin
    flags     = '0;
    rsp_paddr = '0;
    rsp_eaddr = '0;
    if (req_valid) begin
      if (exec_sel) begin
        flags.exec = 1'b1;
        rsp_eaddr  = req_addr[EA_W-1:0];
      end else if (!any_hit) begin
        flags.fmiss = 1'b1;
      end else begin
        flags.multi = many_hit;
        if (lock_vec[win_idx]) flags.flock = 1'b1;
        else                   rsp_paddr   = {win_idx, req_off};
      end
    end
  end

  assign rsp_exec       = flags.exec;
  assign rsp_fault_miss = flags.fmiss;
  assign rsp_fault_lock = flags.flock;
  assign rsp_multi      = flags.multi;
  assign rsp_valid      = req_valid;
  assign req_ready      = rsp_ready;
endmodule

// File: rtl/pat_xlate_chk.sv
module pat_xlate_chk #(
  parameter int BLK_W = 11,
  parameter int OFF_W = 9,
  parameter int FRM_W = 5,
  localparam int VA_W = BLK_W + OFF_W + 1,
  localparam int PA_W = FRM_W + OFF_W,
  localparam int EA_W = BLK_W + OFF_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [BLK_W-1:0] wr_block,
  input logic             req_valid,
  input logic [VA_W-1:0]  req_addr,
  input logic             rsp_valid,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [EA_W-1:0]  rsp_eaddr,
  input logic             rsp_exec,
  input logic             rsp_fault_miss,
  input logic             rsp_fault_lock,
  input logic             rsp_multi
);
  // R3
  exec_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && req_addr[VA_W-1]) |->
      (rsp_exec && !rsp_fault_miss && !rsp_fault_lock && !rsp_multi && rsp_paddr == '0
       && rsp_eaddr == req_addr[EA_W-1:0]));

  // R6
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_exec, rsp_fault_miss, rsp_fault_lock}));

  // R5
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault_miss || rsp_fault_lock) |-> (rsp_paddr == '0));

  // R4
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_exec && !rsp_fault_miss && !rsp_fault_lock)
      |-> (rsp_paddr[OFF_W-1:0] == req_addr[OFF_W-1:0]));

  // R7
  load_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && rsp_valid && !req_addr[VA_W-1]
     && req_addr[VA_W-2 -: BLK_W] == $past(wr_block)) |-> !rsp_fault_miss);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!rsp_exec && !rsp_fault_miss && !rsp_fault_lock && !rsp_multi
                    && rsp_paddr == '0 && rsp_eaddr == '0));
endmodule

bind pat_xlate pat_xlate_chk #(.BLK_W(BLK_W), .OFF_W(OFF_W), .FRM_W(FRM_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .wr_block      (wr_block),
  .req_valid     (req_valid),
  .req_addr      (req_addr),
  .rsp_valid     (rsp_valid),
  .rsp_paddr     (rsp_paddr),
  .rsp_eaddr     (rsp_eaddr),
  .rsp_exec      (rsp_exec),
  .rsp_fault_miss(rsp_fault_miss),
  .rsp_fault_lock(rsp_fault_lock),
  .rsp_multi     (rsp_multi)
);

// File: tb/sim_pat_xlate.sv
module sim_pat_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_lock, lk_en, lk_val;
  logic [4:0]  wr_frame, lk_frame;
  logic [10:0] wr_block;
  logic        req_valid, rsp_ready;
  logic [20:0] req_addr;
  logic        req_ready, rsp_valid;
  logic [13:0] rsp_paddr;
  logic [19:0] rsp_eaddr;
  logic        rsp_exec, rsp_fault_miss, rsp_fault_lock, rsp_multi;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pat_xlate u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_frame(wr_frame), .wr_block(wr_block), .wr_lock(wr_lock),
    .lk_en(lk_en), .lk_frame(lk_frame), .lk_val(lk_val),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_eaddr(rsp_eaddr), .rsp_exec(rsp_exec),
    .rsp_fault_miss(rsp_fault_miss), .rsp_fault_lock(rsp_fault_lock), .rsp_multi(rsp_multi)
  );

  // vector: {req id[3:0], multi, exec, lock fault, miss fault, paddr[13:0], addr[20:0]}
  localparam int NV = 10;
  localparam logic [42:0] VECS [NV] = '{
    {4'd4,  1'b0, 1'b0, 1'b0, 1'b0, 14'h07FF, 21'h000BFF},  // R4 frame 3
    {4'd6,  1'b0, 1'b0, 1'b1, 1'b0, 14'h0000, 21'h024604},  // R6 frame 7 locked
    {4'd2,  1'b0, 1'b0, 1'b0, 1'b0, 14'h3E00, 21'h0FFE00},  // R2 top block, frame 31
    {4'd4,  1'b0, 1'b0, 1'b0, 1'b0, 14'h0055, 21'h008055},  // R4 frame 0
    {4'd10, 1'b1, 1'b0, 1'b0, 1'b0, 14'h1401, 21'h015401},  // R10 frames 10,12
    {4'd10, 1'b1, 1'b0, 1'b1, 1'b0, 14'h0000, 21'h017602},  // R10 frames 20(lock),25
    {4'd5,  1'b0, 1'b0, 1'b0, 1'b1, 14'h0000, 21'h000C00},  // R5 block 6 absent
    {4'd3,  1'b0, 1'b1, 1'b0, 1'b0, 14'h0000, 21'h100BFF},  // R3 bypass, block 5 resident
    {4'd3,  1'b0, 1'b1, 1'b0, 1'b0, 14'h0000, 21'h1FFFFF},  // R3 bypass all ones
    {4'd5,  1'b0, 1'b0, 1'b0, 1'b1, 14'h0000, 21'h000000}   // R5 block 0 absent
  };

  task automatic look(input logic [20:0] a, input logic em, input logic el,
                      input logic ee, input logic emu, input logic [13:0] ep,
                      input string tag);
    logic [19:0] exp_e;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    #1;
    exp_e = ee ? a[19:0] : 20'h0;
    checks++;
    if ({rsp_valid, rsp_fault_miss, rsp_fault_lock, rsp_exec, rsp_multi, rsp_paddr, rsp_eaddr}
        !== {1'b1, em, el, ee, emu, ep, exp_e}) begin
      failures++;
      $display("FAIL %s addr=%h actual miss=%b lock=%b exec=%b multi=%b pa=%h ea=%h expected miss=%b lock=%b exec=%b multi=%b pa=%h ea=%h",
               tag, a, rsp_fault_miss, rsp_fault_lock, rsp_exec, rsp_multi, rsp_paddr, rsp_eaddr,
               em, el, ee, emu, ep, exp_e);
    end
  endtask

  task automatic load(input logic [4:0] f, input logic [10:0] b, input logic l);
    @(negedge clk);
    wr_en = 1'b1; wr_frame = f; wr_block = b; wr_lock = l;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setlock(input logic [4:0] f, input logic v);
    @(negedge clk);
    lk_en = 1'b1; lk_frame = f; lk_val = v;
    @(negedge clk);
    lk_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_lock = 0; lk_en = 0; lk_val = 0;
    wr_frame = '0; lk_frame = '0; wr_block = '0;
    req_valid = 0; req_addr = '0; rsp_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 empty after reset: block 0 and block 5 both miss
    look(21'h000000, 1, 0, 0, 0, 14'h0, "R1");
    look(21'h000BFF, 1, 0, 0, 0, 14'h0, "R1");

    load(5'd3,  11'h005, 1'b0);
    load(5'd7,  11'h123, 1'b1);
    load(5'd31, 11'h7FF, 1'b0);
    load(5'd0,  11'h040, 1'b0);
    load(5'd10, 11'h0AA, 1'b0);
    load(5'd12, 11'h0AA, 1'b1);
    load(5'd20, 11'h0BB, 1'b1);
    load(5'd25, 11'h0BB, 1'b0);

    for (int i = 0; i < NV; i++) begin
      look(VECS[i][20:0], VECS[i][35], VECS[i][36], VECS[i][37], VECS[i][38],
           VECS[i][34:21], $sformatf("R%0d vec%0d", VECS[i][42:39], i));
    end

    // R8 lock frame 3 keeps its block: lock fault, then unlock: hit again
    setlock(5'd3, 1'b1);
    look(21'h000BFF, 0, 1, 0, 0, 14'h0, "R8 locked");
    setlock(5'd3, 1'b0);
    look(21'h000BFF, 0, 0, 0, 0, 14'h07FF, "R8 unlocked");

    // R9 load and lock on frame 3 together: load's lock (0) wins
    @(negedge clk);
    wr_en = 1; wr_frame = 5'd3; wr_block = 11'h006; wr_lock = 0;
    lk_en = 1; lk_frame = 5'd3; lk_val = 1;
    @(negedge clk);
    wr_en = 0; lk_en = 0;
    look(21'h000C10, 0, 0, 0, 0, 14'h0610, "R9");
    // R7 old block 5 replaced in frame 3
    look(21'h000BFF, 1, 0, 0, 0, 14'h0, "R7 replaced");

    // R11 idle and back-pressure
    @(negedge clk);
    req_valid = 0; req_addr = 21'h000C10; rsp_ready = 0;
    #1;
    checks++;
    if ({rsp_valid, req_ready, rsp_fault_miss, rsp_fault_lock, rsp_exec, rsp_multi, rsp_paddr, rsp_eaddr} !== '0) begin
      failures++;
      $display("FAIL R11 idle actual valid=%b ready=%b pa=%h ea=%h expected all zero",
               rsp_valid, req_ready, rsp_paddr, rsp_eaddr);
    end
    @(negedge clk);
    req_valid = 1; rsp_ready = 0;
    #1;
    checks++;
    if ({rsp_valid, req_ready, rsp_paddr} !== {1'b1, 1'b0, 14'h0610}) begin
      failures++;
      $display("FAIL R11 stall actual valid=%b ready=%b pa=%h expected 1 0 0610",
               rsp_valid, req_ready, rsp_paddr);
    end
    @(negedge clk);
    rsp_ready = 1;
    #1;
    checks++;
    if ({rsp_valid, req_ready, rsp_paddr} !== {1'b1, 1'b1, 14'h0610}) begin
      failures++;
      $display("FAIL R11 accept actual valid=%b ready=%b pa=%h expected 1 1 0610",
               rsp_valid, req_ready, rsp_paddr);
    end

    // R1 reset clears loaded frames
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    look(21'h0FFE00, 1, 0, 0, 0, 14'h0, "R1 after re-reset");

    finish_run();
  end
endmodule